// File: doc/BRIEF.md
# Pipelined-Address Bus Cycle Controller

This block is the processor-side sequencer for an external bus. It takes one request at a time from the core and runs a read or write cycle for it. The cycle has a first clock that drives the address with an active-low strobe, then wait clocks that end when the device pulls the active-low ready input. A device that can accept the next address early pulls the active-low next-address input. The controller then drives the following address and strobe while the current cycle is still waiting for ready, so back-to-back cycles overlap. The shortest overlapped cycle takes two clocks.

A request marked wide carries a 32-bit operand. If the device reports a 16-bit bus during the first clock of that cycle, the controller runs a second cycle at the address plus two for the upper half. That second half is queued ahead of any new core request, so once early addressing is granted it is the half that gets issued early. A hold request gives the bus to another master, but only at a cycle boundary with no address already out, or from idle.

The request side is valid/ready. The core raises `req_valid` with address, write flag and wide flag, and keeps all four stable until it sees `req_ready` high in a clock. That clock is the one in which the address goes out. `req_ready` is never high for the second half of a split operand. Bus-side pins are plain control levels.

Top module: `bus_pipe_ctrl`

## Requirements
- R1: While reset is low and in the first clock after it, `bus_state` reads 0 (idle), `as_n` is high, `hlda` is low and `req_ready` is low. The state codes are idle=0, T1=1, T2=2, T2I=3, T2P=4, T1P=5, hold=6.
- R2: From idle, with no hold, a request moves the controller to T1 in the next clock. In T1, `as_n` is low, `bus_addr` shows the request address and `req_ready` is high.
- R3: T1 is always followed by T2. T2 repeats while `rdy_n` and `nxt_n` are both high.
- R4: `rdy_n` low in T2, T2I or T2P ends the cycle. The next state is T1 if work is pending, otherwise idle, unless rule R8 applies.
- R5: `nxt_n` low in T2 or T1P moves the controller to T2P when work is pending, otherwise to T2I. T2I drives no strobe and moves to T2P when work appears.
- R6: The first T2P clock of a cycle issues the next address with `as_n` low. Later T2P clocks of the same cycle keep `as_n` high.
- R7: `rdy_n` low once the next address has been issued leads to T1P. T1P lasts one clock and ignores `rdy_n`. It is followed by T2P or T2I when `nxt_n` is low, and by T2 otherwise.
- R8: Hold is taken at a cycle end with no early address out, or from idle, and it wins over a pending request. An early address already issued wins over hold.
- R9: The controller stays in hold with `hlda` high while `hold` is high. Once `hold` is low, it moves to T1 or idle and `hlda` drops in that next clock.
- R10: A wide request whose first clock (T1 or T1P) sees `bs16_n` low gets a second cycle at the address plus 2. That cycle has the same write flag and no `req_ready`, and it is issued before any new request.
- R11: With `bs16_n` high, a wide request takes one cycle. A second-half cycle never splits again.
- R12: `bus_wr` shows the write flag of the request in the clock its address is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request taken this clock |
| req_addr | input | AW | Request byte address |
| req_write | input | 1 | Request is a write |
| req_wide | input | 1 | Operand needs both 16-bit halves |
| rdy_n | input | 1 | Device ends cycle, active low |
| nxt_n | input | 1 | Device asks for next address early, active low |
| hold | input | 1 | Another master wants the bus |
| bs16_n | input | 1 | Device has a 16-bit bus, active low |
| bus_addr | output | AW | Bus address |
| bus_wr | output | 1 | Bus write flag |
| as_n | output | 1 | Address strobe, active low |
| hlda | output | 1 | Hold acknowledge |
| bus_state | output | 3 | Current bus state code |

## Verification
Two events can coincide in the T2P clock: issuing the early address and the device ending the current cycle. The bench provokes this twice, once plain and once with `hold` raised in the same clock. In both cases it expects a strobe with the new address in that clock and T1P in the next, with no hold. A second overlap is the split second half issued early while a new core request waits. There the bench expects the strobe at address plus 2 with `req_ready` low, and it expects the waiting request to be taken only in a later T1.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T2I  = 3'd3,
    ST_T2P  = 3'd4,
    ST_T1P  = 3'd5,
    ST_HOLD = 3'd6
  } bus_st_e;
endpackage

// File: rtl/bpc_fsm.sv
module bpc_fsm
  import bpc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pending,
  input  logic    rdy_n,
  input  logic    nxt_n,
  input  logic    hold,
  output bus_st_e st,
  output logic    issue
);
  bus_st_e st_nxt;
  logic    piped;
  logic    addr_out;

  always_comb begin
    issue    = (st == ST_T1) || (st == ST_T2P && !piped);
    addr_out = piped || (st == ST_T2P);
    st_nxt   = st;
    case (st)
      ST_IDLE, ST_HOLD: st_nxt = hold ? ST_HOLD : (pending ? ST_T1 : ST_IDLE);
      ST_T1:            st_nxt = ST_T2;
      ST_T1P:           st_nxt = !nxt_n ? (pending ? ST_T2P : ST_T2I) : ST_T2;
      ST_T2, ST_T2I, ST_T2P: begin
        if (!rdy_n)
          st_nxt = addr_out ? ST_T1P : (hold ? ST_HOLD : (pending ? ST_T1 : ST_IDLE));
        else if (st == ST_T2)
          st_nxt = !nxt_n ? (pending ? ST_T2P : ST_T2I) : ST_T2;
        else if (st == ST_T2I)
          st_nxt = pending ? ST_T2P : ST_T2I;
        else
          st_nxt = ST_T2P;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      piped <= 1'b0;
    end else begin
      st    <= st_nxt;
      piped <= (st_nxt == ST_T2P) && (st == ST_T2P);
    end
  end

  // R3
  t1_to_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_T1 |=> st == ST_T2);
  // R7
  t1p_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_T1P |=> (st == ST_T2 || st == ST_T2I || st == ST_T2P));
  // R7
  piped_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_T2P && !rdy_n) |=> st == ST_T1P);
  // R9
  hold_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD && hold) |=> st == ST_HOLD);
  // R8
  hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD && $past(st) != ST_HOLD) |-> !$past(piped) && $past(st) != ST_T2P);
endmodule

// File: rtl/bpc_issue.sv
module bpc_issue
  import bpc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_st_e       st,
  input  logic          issue,
  input  logic          bs16_n,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_wide,
  output logic          split_pend,
  output logic          req_ready,
  output logic [AW-1:0] bus_addr,
  output logic          bus_wr
);
  localparam logic [AW-1:0] HALF_STEP = AW'(WORD_BYTES / 2);

  logic [AW-1:0] cur_addr, pip_addr, last_addr, iss_addr;
  logic          cur_wr, pip_wr, last_wr, iss_wr;
  logic          pip_wide, pip_h2, iss_wide, iss_h2;
  logic          first_wide, first_h2, split_set;

  always_comb begin
    iss_addr   = split_pend ? cur_addr + HALF_STEP : req_addr;
    iss_wr     = split_pend ? cur_wr : req_write;
    iss_wide   = split_pend ? 1'b0 : req_wide;
    iss_h2     = split_pend;
    first_wide = (st == ST_T1) ? iss_wide : pip_wide;
    first_h2   = (st == ST_T1) ? iss_h2 : pip_h2;
    split_set  = (st == ST_T1 || st == ST_T1P) && first_wide && !first_h2 && !bs16_n;
    req_ready  = issue && !split_pend;
    bus_addr   = issue ? iss_addr : last_addr;
    bus_wr     = issue ? iss_wr : last_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr   <= '0;
      cur_wr     <= 1'b0;
      pip_addr   <= '0;
      pip_wr     <= 1'b0;
      pip_wide   <= 1'b0;
      pip_h2     <= 1'b0;
      last_addr  <= '0;
      last_wr    <= 1'b0;
      split_pend <= 1'b0;
    end else begin
      if (issue) begin
        last_addr <= iss_addr;
        last_wr   <= iss_wr;
        if (st == ST_T1) begin
          cur_addr <= iss_addr;
          cur_wr   <= iss_wr;
        end else begin
          pip_addr <= iss_addr;
          pip_wr   <= iss_wr;
          pip_wide <= iss_wide;
          pip_h2   <= iss_h2;
        end
      end else if (st == ST_T1P) begin
        cur_addr <= pip_addr;
        cur_wr   <= pip_wr;
      end
      if (issue && split_pend) split_pend <= 1'b0;
      else if (split_set)      split_pend <= 1'b1;
    end
  end

  // R10
  split_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && split_pend) |=> !split_pend);
  // R10
  split_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(split_pend) |-> ($past(st) == ST_T1 || $past(st) == ST_T1P));
endmodule

// File: rtl/bus_pipe_ctrl.sv
module bus_pipe_ctrl
  import bpc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_wide,
  input  logic          rdy_n,
  input  logic          nxt_n,
  input  logic          hold,
  input  logic          bs16_n,
  output logic [AW-1:0] bus_addr,
  output logic          bus_wr,
  output logic          as_n,
  output logic          hlda,
  output logic [2:0]    bus_state
);
  bus_st_e st;
  logic    issue, split_pend, pending;

  assign pending   = req_valid || split_pend;
  assign as_n      = !issue;
  assign hlda      = (st == ST_HOLD);
  assign bus_state = st;

  bpc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pending(pending), .rdy_n(rdy_n),
    .nxt_n(nxt_n), .hold(hold), .st(st), .issue(issue)
  );

  bpc_issue #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_issue (
    .clk(clk), .rst_n(rst_n), .st(st), .issue(issue), .bs16_n(bs16_n),
    .req_addr(req_addr), .req_write(req_write), .req_wide(req_wide),
    .split_pend(split_pend), .req_ready(req_ready),
    .bus_addr(bus_addr), .bus_wr(bus_wr)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (st == ST_IDLE && as_n && !hlda));
endmodule

// File: tb/bus_pipe_ctrl_tb.sv
`timescale 1ns/1ps
module bus_pipe_ctrl_tb;
  localparam int AW = 32;
  localparam int NV = 46;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, req_wide;
  logic rdy_n, nxt_n, hold, bs16_n, bus_wr, as_n, hlda;
  logic [AW-1:0] req_addr, bus_addr;
  logic [2:0] bus_state;
  int n_chk = 0;
  int n_fail = 0;

  bus_pipe_ctrl #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wide(req_wide),
    .rdy_n(rdy_n), .nxt_n(nxt_n), .hold(hold), .bs16_n(bs16_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .as_n(as_n), .hlda(hlda),
    .bus_state(bus_state)
  );

  // fields: req tag, rv, wide, wr, addr, rdy_n, nxt_n, hold, bs16_n | state, as_n, hlda, take, bus addr
  function automatic logic [32:0] mk(input logic [3:0] rq, input logic rv, wd, wr,
      input logic [7:0] ad, input logic rd, nx, hd, bs,
      input logic [2:0] es, input logic eas, ehl, etk, input logic [7:0] ea);
    return {rq, rv, wd, wr, ad, rd, nx, hd, bs, es, eas, ehl, etk, ea};
  endfunction

  localparam logic [32:0] VEC [NV] = '{
    mk(1, 0,0,0,8'h00, 1,1,0,1, 0,1,0,0,8'h00),  // R1 idle
    mk(2, 1,0,1,8'h10, 1,1,0,1, 0,1,0,0,8'h00),  // R2 request seen
    mk(2, 1,0,1,8'h10, 1,1,0,1, 1,0,0,1,8'h10),  // R2 T1 issue
    mk(3, 0,0,0,8'h00, 1,1,0,1, 2,1,0,0,8'h00),  // R3 wait
    mk(4, 0,0,0,8'h00, 0,1,0,1, 2,1,0,0,8'h00),  // R4 ready
    mk(4, 0,0,0,8'h00, 1,1,0,1, 0,1,0,0,8'h00),  // R4 back to idle
    mk(2, 1,0,0,8'h20, 1,1,0,1, 0,1,0,0,8'h00),
    mk(2, 1,0,0,8'h20, 1,1,0,1, 1,0,0,1,8'h20),
    mk(5, 0,0,0,8'h00, 1,0,0,1, 2,1,0,0,8'h00),  // R5 early addr, nothing pending
    mk(5, 1,0,1,8'h30, 1,1,0,1, 3,1,0,0,8'h00),  // R5 T2I no strobe
    mk(6, 1,0,1,8'h30, 1,1,0,1, 4,0,0,1,8'h30),  // R6 T2P issue
    mk(6, 0,0,0,8'h00, 0,1,0,1, 4,1,0,0,8'h00),  // R6 later T2P no strobe
    mk(7, 1,0,0,8'h40, 1,0,0,1, 5,1,0,0,8'h00),  // R7 T1P
    mk(6, 1,0,0,8'h40, 0,1,0,1, 4,0,0,1,8'h40),  // R6 issue and ready together
    mk(7, 0,0,0,8'h00, 1,1,0,1, 5,1,0,0,8'h00),  // R7
    mk(8, 0,0,0,8'h00, 0,1,1,1, 2,1,0,0,8'h00),  // R8 hold at end
    mk(9, 1,1,1,8'h50, 1,1,1,1, 6,1,1,0,8'h00),  // R9 hold kept
    mk(9, 1,1,1,8'h50, 1,1,0,1, 6,1,1,0,8'h00),  // R9 hold released
    mk(10,1,1,1,8'h50, 1,1,0,0, 1,0,0,1,8'h50),  // R10 wide, 16-bit
    mk(10,0,0,0,8'h00, 1,0,0,1, 2,1,0,0,8'h00),
    mk(10,1,1,0,8'h60, 1,1,0,1, 4,0,0,0,8'h52),  // R10 second half early, no take
    mk(10,1,1,0,8'h60, 0,1,0,1, 4,1,0,0,8'h00),
    mk(11,1,1,0,8'h60, 0,1,0,0, 5,1,0,0,8'h00),  // R11 R7 no resplit, ready ignored
    mk(4, 1,1,0,8'h60, 0,1,0,1, 2,1,0,0,8'h00),  // R4 end with pending
    mk(11,1,1,0,8'h60, 1,1,0,1, 1,0,0,1,8'h60),  // R11 wide, 32-bit bus
    mk(11,0,0,0,8'h00, 0,1,0,1, 2,1,0,0,8'h00),
    mk(8, 1,0,1,8'h70, 1,1,1,1, 0,1,0,0,8'h00),  // R8 hold beats request
    mk(9, 1,0,1,8'h70, 1,1,0,1, 6,1,1,0,8'h00),
    mk(9, 1,0,1,8'h70, 1,1,0,1, 1,0,0,1,8'h70),  // R9 hlda gone
    mk(5, 1,0,0,8'h80, 1,0,0,1, 2,1,0,0,8'h00),
    mk(8, 1,0,0,8'h80, 0,1,1,1, 4,0,0,1,8'h80),  // R8 early addr beats hold
    mk(8, 0,0,0,8'h00, 1,1,1,1, 5,1,0,0,8'h00),
    mk(8, 0,0,0,8'h00, 0,1,1,1, 2,1,0,0,8'h00),
    mk(9, 0,0,0,8'h00, 1,1,0,1, 6,1,1,0,8'h00),
    mk(9, 0,0,0,8'h00, 1,1,0,1, 0,1,0,0,8'h00),
    mk(10,1,1,0,8'h90, 1,1,0,1, 0,1,0,0,8'h00),
    mk(10,1,1,0,8'h90, 1,1,0,0, 1,0,0,1,8'h90),
    mk(10,0,0,0,8'h00, 0,1,0,1, 2,1,0,0,8'h00),
    mk(10,0,0,0,8'h00, 1,1,0,1, 1,0,0,0,8'h92),  // R10 second half in T1
    mk(10,0,0,0,8'h00, 0,1,0,1, 2,1,0,0,8'h00),
    mk(10,0,0,0,8'h00, 1,1,0,1, 0,1,0,0,8'h00),
    mk(2, 1,0,0,8'hA0, 1,1,0,1, 0,1,0,0,8'h00),
    mk(2, 1,0,0,8'hA0, 1,1,0,1, 1,0,0,1,8'hA0),
    mk(5, 0,0,0,8'h00, 1,0,0,1, 2,1,0,0,8'h00),
    mk(4, 0,0,0,8'h00, 0,1,0,1, 3,1,0,0,8'h00),  // R4 ready in T2I
    mk(4, 0,0,0,8'h00, 1,1,0,1, 0,1,0,0,8'h00)
  };

  task automatic chk(input string what, input int rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic idle_in();
    req_valid = 0; req_addr = '0; req_write = 0; req_wide = 0;
    rdy_n = 1; nxt_n = 1; hold = 0; bs16_n = 1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("reset state", 1, 32'(bus_state), 32'd0);
    chk("reset as_n", 1, 32'(as_n), 32'd1);
    chk("reset hlda", 1, 32'(hlda), 32'd0);
    chk("reset req_ready", 1, 32'(req_ready), 32'd0);
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      @(negedge clk);
      v = VEC[i];
      req_valid = v[28]; req_wide = v[27]; req_write = v[26];
      req_addr = {24'b0, v[25:18]};
      rdy_n = v[17]; nxt_n = v[16]; hold = v[15]; bs16_n = v[14];
      #1;
      chk($sformatf("vec %0d state", i), int'(v[32:29]), 32'(bus_state), 32'(v[13:11]));
      chk($sformatf("vec %0d as_n", i), int'(v[32:29]), 32'(as_n), 32'(v[10]));
      chk($sformatf("vec %0d hlda", i), int'(v[32:29]), 32'(hlda), 32'(v[9]));
      chk($sformatf("vec %0d req_ready", i), int'(v[32:29]), 32'(req_ready), 32'(v[8]));
      if (!v[10]) chk($sformatf("vec %0d bus_addr", i), int'(v[32:29]), bus_addr, {24'b0, v[7:0]});
      if (v[8]) chk($sformatf("vec %0d bus_wr R12", i), 12, 32'(bus_wr), 32'(v[26]));
    end
    // R1: reset in the middle of a cycle returns to idle at once
    @(negedge clk);
    idle_in(); req_valid = 1; req_addr = 32'hB0;
    @(negedge clk); req_valid = 0;
    @(negedge clk);
    #1 chk("mid-cycle in T2", 3, 32'(bus_state), 32'd2);
    rst_n = 0;
    #1;
    chk("async reset state", 1, 32'(bus_state), 32'd0);
    chk("async reset as_n", 1, 32'(as_n), 32'd1);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    #1 chk("after reset idle", 1, 32'(bus_state), 32'd0);
    finish_run();
  end
endmodule